// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block is a watchdog with two countdown stages in series. Software loads a preload value for each stage through a small register port. The first stage then counts down. When it runs out, it raises an interrupt status and starts the second stage. When the second stage runs out, the block sets a sticky timeout flag and drives a level reset request toward the system reset generator. Software prevents this by writing a keepalive command before the first stage expires. The keepalive reloads both stages from their preload values.

Every write to a preload register or to the control/reload word must be preceded by a two-write key sequence on that word. Each completed key admits exactly one such write. A second, narrower port holds the configuration word and the lock word. The configuration word selects the tick divisor, the interrupt routing and the reset suppression. The lock word holds the enable bit, a mode bit and a lock bit. Once the lock bit is set, the lock word can no longer be changed.

Two resets are used. `por_n` clears everything. `rst_n` is the soft reset that the watchdog itself may cause, and it clears everything except the timeout flag. The flag therefore tells software after the reset whether the watchdog fired.

Top module: `wdt2_top`

## Requirements
- R1: Writing 0x80 and then 0x86 (low 16 bits of the data) to offset 0x0C opens the protected window. The next protected write is accepted, and the window then closes. Protected writes are writes to offsets 0x00, 0x04 and 0x0C.
- R2: A protected write made while the window is closed is dropped. Any register-port write that is not the next expected step of the key resets the key sequence.
- R3: The stage-1 preload sits at offset 0x00 and the stage-2 preload at offset 0x04. Each is 20 bits wide; bits 31:20 are ignored on write and read as zero. Both preloads reset to 1023.
- R4: An accepted write with bit 8 set to offset 0x0C reloads both stages and the tick prescaler. The next stage-1 expiry is then due a full stage-1 period after that write.
- R5: Stage 1 expires 2^k·(P1+1) cycles after enable or reload, where P1 is the stage-1 preload and 2^k is the tick divisor. On expiry it sets bit 0 at offset 0x08. That bit is cleared by writing 1 to it; no key is needed. The `irq` output follows this bit unless configuration bits 1:0 equal 11.
- R6: Stage 2 expires a further 2^k·(P2+1) cycles after stage 1 expires, where P2 is the stage-2 preload. On expiry it sets the timeout flag, read at bit 9 of offset 0x0C. `wdt_rst` rises at the same time when configuration bit 5 is 0 and stays low when that bit is 1.
- R7: The timeout flag survives `rst_n`. It is cleared by `por_n` or by an accepted write with bit 9 set to offset 0x0C.
- R8: The lock word is reached with `cfg_sel`=1: bit 0 is lock, bit 1 is enable, bit 2 is mode. While lock is 1, writes to the lock word are ignored until a reset.
- R9: While enable is 0, both stages are held at their preloads and neither `irq` nor `wdt_rst` is raised by counting. Enabling again starts a full stage-1 period.
- R10: Configuration bit 2 selects the tick divisor: 0 gives 2^15 clock cycles per tick, 1 gives 2^5.
- R11: With mode bit 2 = 1 the block runs as a periodic timer. Stage-2 expiry restarts stage 1, sets no timeout flag and raises no reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| por_n | input | 1 | Power-on reset, active low, clears everything |
| rst_n | input | 1 | Soft reset, active low, keeps the timeout flag |
| reg_we | input | 1 | Register port write strobe |
| reg_addr | input | 4 | Register byte offset (bits 3:2 decoded) |
| reg_wdata | input | 32 | Register port write data |
| reg_rdata | output | 32 | Register port read data, combinational from reg_addr |
| cfg_we | input | 1 | Configuration port write strobe |
| cfg_sel | input | 1 | 0 = configuration word, 1 = lock word |
| cfg_wdata | input | 16 | Configuration port write data |
| cfg_rdata | output | 16 | Configuration port read data, combinational from cfg_sel |
| irq | output | 1 | Stage-1 expiry interrupt, level |
| wdt_rst | output | 1 | Stage-2 expiry reset request, level |

## Verification
Every write lands on the clock edge inside the write task, and register reads are combinational. Each readback is therefore taken at the falling edge right after that write.

For the timing results, the bench counts falling edges starting from the edge that enabled the block or accepted the keepalive. Stage-1 expiry must first appear in `irq` after exactly 2^k·(P1+1) edges. `wdt_rst` must first appear after 2^k·(P1+1) + 2^k·(P2+1) edges. The bench compares these counts with a bench function of the preload and the divisor.

When a lock-word write falls between the enable edge and the start of counting, the bench subtracts the two cycles that write takes.

// File: rtl/wdt2_pkg.sv
package wdt2_pkg;
  // register port word select (reg_addr[3:2])
  localparam logic [1:0] SEL_PRE1 = 2'd0;
  localparam logic [1:0] SEL_PRE2 = 2'd1;
  localparam logic [1:0] SEL_STAT = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;

  // key sequence on the control word
  localparam logic [15:0] KEY_FIRST  = 16'h0080;
  localparam logic [15:0] KEY_SECOND = 16'h0086;

  // control word bits
  localparam int CTRL_KICK = 8;
  localparam int CTRL_TMO  = 9;

  // configuration word bits
  localparam int CF_NORST = 5;
  localparam int CF_FAST  = 2;

  // lock word bits
  localparam int LK_LOCK = 0;
  localparam int LK_EN   = 1;
  localparam int LK_MODE = 2;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_ARMED = 2'd1,
    UL_OPEN  = 2'd2
  } unlock_e;
endpackage

// File: rtl/wdt2_rst_sync.sv
module wdt2_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sh_q[STAGES-1];
endmodule

// File: rtl/wdt2_unlock.sv
module wdt2_unlock
  import wdt2_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_i,
  input  logic [1:0]  sel_i,
  input  logic [15:0] key_i,
  output logic        grant_o
);
  unlock_e state_q, state_d;
  logic    prot_wr;

  assign prot_wr = wr_i && (sel_i != SEL_STAT);
  assign grant_o = prot_wr && (state_q == UL_OPEN);

  always_comb begin
    state_d = state_q;
    if (wr_i) begin
      unique case (state_q)
        UL_IDLE:  state_d = (sel_i == SEL_CTRL && key_i == KEY_FIRST)  ? UL_ARMED : UL_IDLE;
        UL_ARMED: state_d = (sel_i == SEL_CTRL && key_i == KEY_SECOND) ? UL_OPEN  : UL_IDLE;
        default:  state_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= UL_IDLE;
    else        state_q <= state_d;
  end

  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    grant_o |=> (state_q == UL_IDLE)); // R1
  AST_OPEN_FROM_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == UL_OPEN && $past(state_q) != UL_OPEN) |-> ($past(state_q) == UL_ARMED)); // R2
endmodule

// File: rtl/wdt2_prescaler.sv
module wdt2_prescaler #(
  parameter int SLOW_LG = 15,
  parameter int FAST_LG = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic clr_i,
  input  logic fast_i,
  output logic tick_o
);
  logic [SLOW_LG-1:0] div_q, div_d;

  always_comb begin
    if (!run_i || clr_i) div_d = '0;
    else                 div_d = div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign tick_o = run_i && (fast_i ? (&div_q[FAST_LG-1:0]) : (&div_q));

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o); // R10
endmodule

// File: rtl/wdt2_stages.sv
module wdt2_stages #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             reload_i,
  input  logic             tick_i,
  input  logic             periodic_i,
  input  logic [CNT_W-1:0] pre1_i,
  input  logic [CNT_W-1:0] pre2_i,
  output logic             s1_exp_o,
  output logic             s2_exp_o,
  output logic             expired_o
);
  logic             second_q, second_d;
  logic             done_q, done_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    second_d = second_q;
    done_d   = done_q;
    cnt_d    = cnt_q;
    s1_exp_o = 1'b0;
    s2_exp_o = 1'b0;
    if (!run_i || reload_i) begin
      second_d = 1'b0;
      done_d   = 1'b0;
      cnt_d    = pre1_i;
    end else if (tick_i && !done_q) begin
      if (cnt_q != '0) begin
        cnt_d = cnt_q - 1'b1;
      end else if (!second_q) begin
        s1_exp_o = 1'b1;
        second_d = 1'b1;
        cnt_d    = pre2_i;
      end else begin
        s2_exp_o = 1'b1;
        if (periodic_i) begin
          second_d = 1'b0;
          cnt_d    = pre1_i;
        end else begin
          done_d = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
    end else begin
      second_q <= second_d;
      done_q   <= done_d;
      cnt_q    <= cnt_d;
    end
  end

  assign expired_o = done_q;

  AST_HOLD_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (cnt_q == $past(pre1_i)) && !done_q && !second_q); // R9
endmodule

// File: rtl/wdt2_top.sv
module wdt2_top
  import wdt2_pkg::*;
#(
  parameter int               CNT_W       = 20,
  parameter int               SLOW_LG     = 15,
  parameter int               FAST_LG     = 5,
  parameter logic [CNT_W-1:0] PRELOAD_RST = CNT_W'(1023)
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [3:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        cfg_we,
  input  logic        cfg_sel,
  input  logic [15:0] cfg_wdata,
  output logic [15:0] cfg_rdata,
  output logic        irq,
  output logic        wdt_rst
);
  logic sys_in_n, por_s_n, sys_s_n;
  assign sys_in_n = por_n & rst_n;

  wdt2_rst_sync #(.STAGES(2)) u_por_sync (.clk(clk), .arst_n(por_n),    .srst_n(por_s_n));
  wdt2_rst_sync #(.STAGES(2)) u_sys_sync (.clk(clk), .arst_n(sys_in_n), .srst_n(sys_s_n));

  logic [1:0]       sel;
  logic             grant, kick, flag_clr, stat_clr;
  logic             tick, s1_exp, s2_exp, expired;
  logic [CNT_W-1:0] pre1_q, pre1_d, pre2_q, pre2_d;
  logic             norst_q, norst_d, fast_q, fast_d;
  logic [1:0]       itype_q, itype_d;
  logic             lock_q, lock_d, en_q, en_d, mode_q, mode_d;
  logic             sts_q, sts_d, tmo_q, tmo_d;

  assign sel = reg_addr[3:2];

  wdt2_unlock u_unlock (
    .clk(clk), .rst_n(sys_s_n), .wr_i(reg_we), .sel_i(sel),
    .key_i(reg_wdata[15:0]), .grant_o(grant)
  );

  assign kick     = grant && (sel == SEL_CTRL) && reg_wdata[CTRL_KICK];
  assign flag_clr = grant && (sel == SEL_CTRL) && reg_wdata[CTRL_TMO];
  assign stat_clr = reg_we && (sel == SEL_STAT) && reg_wdata[0];

  wdt2_prescaler #(.SLOW_LG(SLOW_LG), .FAST_LG(FAST_LG)) u_presc (
    .clk(clk), .rst_n(sys_s_n), .run_i(en_q), .clr_i(kick),
    .fast_i(fast_q), .tick_o(tick)
  );

  wdt2_stages #(.CNT_W(CNT_W)) u_stages (
    .clk(clk), .rst_n(sys_s_n), .run_i(en_q), .reload_i(kick), .tick_i(tick),
    .periodic_i(mode_q), .pre1_i(pre1_q), .pre2_i(pre2_q),
    .s1_exp_o(s1_exp), .s2_exp_o(s2_exp), .expired_o(expired)
  );

  // next-state for the register file
  always_comb begin
    pre1_d  = pre1_q;
    pre2_d  = pre2_q;
    norst_d = norst_q;
    fast_d  = fast_q;
    itype_d = itype_q;
    lock_d  = lock_q;
    en_d    = en_q;
    mode_d  = mode_q;
    if (grant && sel == SEL_PRE1) pre1_d = reg_wdata[CNT_W-1:0];
    if (grant && sel == SEL_PRE2) pre2_d = reg_wdata[CNT_W-1:0];
    if (cfg_we && !cfg_sel) begin
      norst_d = cfg_wdata[CF_NORST];
      fast_d  = cfg_wdata[CF_FAST];
      itype_d = cfg_wdata[1:0];
    end
    if (cfg_we && cfg_sel && !lock_q) begin
      lock_d = cfg_wdata[LK_LOCK];
      en_d   = cfg_wdata[LK_EN];
      mode_d = cfg_wdata[LK_MODE];
    end
    if (s1_exp)        sts_d = 1'b1;
    else if (stat_clr) sts_d = 1'b0;
    else               sts_d = sts_q;
    if (s2_exp && !mode_q) tmo_d = 1'b1;
    else if (flag_clr)     tmo_d = 1'b0;
    else                   tmo_d = tmo_q;
  end

  always_ff @(posedge clk or negedge sys_s_n) begin
    if (!sys_s_n) begin
      pre1_q  <= PRELOAD_RST;
      pre2_q  <= PRELOAD_RST;
      norst_q <= 1'b0;
      fast_q  <= 1'b0;
      itype_q <= 2'b11;
      lock_q  <= 1'b0;
      en_q    <= 1'b0;
      mode_q  <= 1'b0;
      sts_q   <= 1'b0;
    end else begin
      pre1_q  <= pre1_d;
      pre2_q  <= pre2_d;
      norst_q <= norst_d;
      fast_q  <= fast_d;
      itype_q <= itype_d;
      lock_q  <= lock_d;
      en_q    <= en_d;
      mode_q  <= mode_d;
      sts_q   <= sts_d;
    end
  end

  // timeout flag lives in the power-on domain only
  always_ff @(posedge clk or negedge por_s_n) begin
    if (!por_s_n) tmo_q <= 1'b0;
    else          tmo_q <= tmo_d;
  end

  assign irq     = sts_q && (itype_q != 2'b11);
  assign wdt_rst = expired && en_q && !mode_q && !norst_q;

  always_comb begin
    reg_rdata = '0;
    unique case (sel)
      SEL_PRE1: reg_rdata[CNT_W-1:0] = pre1_q;
      SEL_PRE2: reg_rdata[CNT_W-1:0] = pre2_q;
      SEL_STAT: reg_rdata[0]         = sts_q;
      default:  reg_rdata[CTRL_TMO]  = tmo_q;
    endcase
  end

  always_comb begin
    cfg_rdata = '0;
    if (cfg_sel) begin
      cfg_rdata[LK_LOCK] = lock_q;
      cfg_rdata[LK_EN]   = en_q;
      cfg_rdata[LK_MODE] = mode_q;
    end else begin
      cfg_rdata[CF_NORST] = norst_q;
      cfg_rdata[CF_FAST]  = fast_q;
      cfg_rdata[1:0]      = itype_q;
    end
  end

  AST_RST_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!sys_s_n)
    wdt_rst |-> tmo_q); // R6
  AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!sys_s_n)
    lock_q |=> (lock_q && $stable(en_q))); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!por_s_n)
    (tmo_q && !flag_clr) |=> tmo_q); // R7
endmodule

// File: tb/wdt2_top_bench.sv
module wdt2_top_bench;
  logic        clk = 1'b0;
  logic        por_n, rst_n;
  logic        reg_we;
  logic [3:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        cfg_we, cfg_sel;
  logic [15:0] cfg_wdata, cfg_rdata;
  logic        irq, wdt_rst;

  int total = 0;
  int bad   = 0;
  bit ended = 1'b0;

  localparam int FAST = 5;
  localparam int SLOW = 15;

  always #2.5 clk = ~clk;

  wdt2_top u_wdt2_top (
    .clk(clk), .por_n(por_n), .rst_n(rst_n),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .irq(irq), .wdt_rst(wdt_rst)
  );

  function automatic int due(input int pre, input int lg);
    return (pre + 1) << lg;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic cwr(input logic s, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic crd(input logic s, output logic [15:0] d);
    cfg_sel = s;
    #1;
    d = cfg_rdata;
  endtask

  task automatic unlock();
    wr(4'hC, 32'h80);
    wr(4'hC, 32'h86);
  endtask

  task automatic setup(input logic [31:0] p1, input logic [31:0] p2, input logic [15:0] cfg);
    unlock(); wr(4'h0, p1);
    unlock(); wr(4'h4, p2);
    cwr(1'b0, cfg);
  endtask

  task automatic wait_for(input bit on_rst, input int limit, output int n);
    n = 0;
    while (((on_rst ? wdt_rst : irq) !== 1'b1) && n < limit) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic soft_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=done");
    summary();
  end

  initial begin
    logic [31:0] r;
    logic [15:0] c;
    int n1, n2, seed_v;
    bit saw;

    seed_v = $urandom(32'd2024);
    por_n = 1'b0; rst_n = 1'b0;
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
    cfg_we = 1'b0; cfg_sel = 1'b0; cfg_wdata = '0;
    repeat (4) @(negedge clk);
    por_n = 1'b1; rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // reset state
    rd(4'h0, r); chk("R3 reset preload1", r, 32'd1023);
    rd(4'h4, r); chk("R3 reset preload2", r, 32'd1023);
    rd(4'h8, r); chk("R5 reset status", r, 32'd0);
    rd(4'hC, r); chk("R7 reset flag", r, 32'd0);
    crd(1'b1, c); chk("R8 reset lock word", {16'd0, c}, 32'd0);
    chk("R9 reset outputs", {30'd0, irq, wdt_rst}, 32'd0);

    // R2: no key, then broken key
    wr(4'h0, 32'd5);
    rd(4'h0, r); chk("R2 write without key dropped", r, 32'd1023);
    wr(4'hC, 32'h80); wr(4'h8, 32'h0); wr(4'hC, 32'h86); wr(4'h0, 32'd5);
    rd(4'h0, r); chk("R2 broken key sequence", r, 32'd1023);

    // R1 / R3: one write per key, upper bits dropped
    unlock(); wr(4'h0, 32'hFFF0_0007);
    rd(4'h0, r); chk("R3 upper bits ignored", r, 32'd7);
    wr(4'h0, 32'd9);
    rd(4'h0, r); chk("R1 second write needs new key", r, 32'd7);

    // random trials
    for (int i = 0; i < 8; i++) begin
      int p1, p2;
      p1 = $urandom % 6;
      p2 = $urandom % 6;
      setup({$urandom % 4096, 20'd0} | 32'(p1), 32'(p2), 16'h0004);
      rd(4'h0, r); chk("R3 preload1 readback", r, 32'(p1));
      cwr(1'b1, 16'h0002);
      wait_for(1'b0, 5000, n1); chk("R5 stage1 due", 32'(n1), 32'(due(p1, FAST)));
      wait_for(1'b1, 5000, n2); chk("R6 stage2 due", 32'(n1 + n2), 32'(due(p1, FAST) + due(p2, FAST)));
      rd(4'hC, r); chk("R6 flag set", r, 32'h200);
      cwr(1'b1, 16'h0000);
      chk("R9 reset drops when disabled", {31'd0, wdt_rst}, 32'd0);
      wr(4'h8, 32'h1);
      rd(4'h8, r); chk("R5 status w1c", r, 32'd0);
      unlock(); wr(4'hC, 32'h200);
      rd(4'hC, r); chk("R7 flag w1c", r, 32'd0);
    end

    // R4 keepalive
    setup(32'd3, 32'd3, 16'h0004);
    cwr(1'b1, 16'h0002);
    saw = 1'b0;
    for (int k = 0; k < 6; k++) begin
      repeat (90) begin @(negedge clk); if (irq) saw = 1'b1; end
      unlock(); wr(4'hC, 32'h100);
      if (irq) saw = 1'b1;
    end
    chk("R4 keepalive holds off irq", {31'd0, saw}, 32'd0);
    wait_for(1'b0, 5000, n1); chk("R4 full period after reload", 32'(n1), 32'(due(3, FAST)));
    cwr(1'b1, 16'h0000); wr(4'h8, 32'h1);

    // R5 interrupt disabled by type 11
    setup(32'd1, 32'd50, 16'h0007);
    cwr(1'b1, 16'h0002);
    saw = 1'b0;
    repeat (due(1, FAST) + 2) begin @(negedge clk); if (irq) saw = 1'b1; end
    chk("R5 type 11 masks irq", {31'd0, saw}, 32'd0);
    rd(4'h8, r); chk("R5 status still set", r, 32'd1);
    cwr(1'b1, 16'h0000); wr(4'h8, 32'h1);

    // R6 reset suppressed
    setup(32'd0, 32'd0, 16'h0024);
    cwr(1'b1, 16'h0002);
    saw = 1'b0;
    repeat (100) begin @(negedge clk); if (wdt_rst) saw = 1'b1; end
    chk("R6 bit5 suppresses reset", {31'd0, saw}, 32'd0);
    rd(4'hC, r); chk("R6 flag set without reset", r, 32'h200);
    cwr(1'b1, 16'h0000); wr(4'h8, 32'h1);

    // R7 soft reset keeps flag, power-on clears it
    soft_reset();
    rd(4'hC, r); chk("R7 flag survives soft reset", r, 32'h200);
    crd(1'b1, c); chk("R7 soft reset clears lock word", {16'd0, c}, 32'd0);
    @(negedge clk); por_n = 1'b0;
    repeat (3) @(negedge clk);
    por_n = 1'b1;
    repeat (5) @(negedge clk);
    rd(4'hC, r); chk("R7 power-on clears flag", r, 32'd0);

    // R8 lock
    setup(32'd2, 32'd100, 16'h0004);
    cwr(1'b1, 16'h0003);
    cwr(1'b1, 16'h0000);
    crd(1'b1, c); chk("R8 locked word frozen", {16'd0, c}, 32'd3);
    wait_for(1'b0, 5000, n1); chk("R8 still running", 32'(n1), 32'(due(2, FAST) - 2));
    soft_reset();
    crd(1'b1, c); chk("R8 reset unlocks", {16'd0, c}, 32'd0);

    // R9 disabled hold and restart
    setup(32'd0, 32'd5, 16'h0004);
    saw = 1'b0;
    repeat (200) begin @(negedge clk); if (irq || wdt_rst) saw = 1'b1; end
    chk("R9 quiet while disabled", {31'd0, saw}, 32'd0);
    cwr(1'b1, 16'h0002);
    repeat (20) @(negedge clk);
    cwr(1'b1, 16'h0000);
    repeat (100) begin @(negedge clk); if (irq) saw = 1'b1; end
    chk("R9 disable mid-run", {31'd0, saw}, 32'd0);
    cwr(1'b1, 16'h0002);
    wait_for(1'b0, 5000, n1); chk("R9 full period on re-enable", 32'(n1), 32'(due(0, FAST)));
    cwr(1'b1, 16'h0000); wr(4'h8, 32'h1);

    // R11 periodic mode
    setup(32'd0, 32'd0, 16'h0004);
    cwr(1'b1, 16'h0006);
    wait_for(1'b0, 5000, n1); chk("R11 first period", 32'(n1), 32'(due(0, FAST)));
    wr(4'h8, 32'h1);
    saw = 1'b0;
    repeat (300) begin @(negedge clk); if (wdt_rst) saw = 1'b1; end
    chk("R11 no reset in periodic mode", {31'd0, saw}, 32'd0);
    rd(4'hC, r); chk("R11 no flag in periodic mode", r, 32'd0);
    rd(4'h8, r); chk("R11 stage1 restarts", r, 32'd1);
    cwr(1'b1, 16'h0000); wr(4'h8, 32'h1);

    // R10 slow divisor
    setup(32'd0, 32'd0, 16'h0000);
    cwr(1'b1, 16'h0002);
    wait_for(1'b0, 40000, n1); chk("R10 slow tick", 32'(n1), 32'(due(0, SLOW)));
    cwr(1'b1, 16'h0000);

    summary();
  end
endmodule